// File: doc/BRIEF.md
# Gain-Ranging AGC Controller with Dwell Timer

This block watches a stream of signed converter samples, one per clock, and steers an external gain-ranging amplifier through a 3-bit gain code. Each step of the code is worth 6.02 dB, so the seven steps add up to 42 dB of extra input range. The comparison uses a coarse magnitude: the absolute value of the sample, limited to the largest positive code and cut down to its upper 10 bits. A magnitude above the upper limit steps the gain down straight away. A magnitude below the lower limit must persist for a programmable dwell time before the gain steps up, which keeps the loop from hunting.

A second output carries the same code as an exponent for the digital relinearization stage downstream. It passes through a programmable delay of 0 to 63 clocks, so that the attenuation applied digitally lines up with the moment the external amplifier has settled. While one change is still travelling through that delay, the block ignores every new request for a change.

All configuration (both thresholds, the dwell count, the settle delay and the enable) arrives as static inputs. A rising edge on the enable restarts the loop at minimum gain.

Top module: `agc_gain_ranger`

## Requirements
- R1: The compared magnitude is min(|x|, 8191) shifted right by 3. Here x is the 14-bit two's-complement sample, so the result holds bits [12:3] of the limited magnitude. Negative and positive samples of equal size act alike, and -8192 maps to 1023.
- R2: Both comparisons are strict. A magnitude equal to the lower limit or equal to the upper limit causes no change.
- R3: Dwell count D is taken as 1 when it is 0. The gain code rises by one only after max(D,1)+1 consecutive magnitudes below the lower limit. Any sample that is not below the limit before then cancels the pending rise, and the count starts again from the beginning.
- R4: A single magnitude above the upper limit lowers the gain code by one, two clock edges after the sample is applied. An above-limit sample takes precedence over a below-limit one. The code never moves by more than one step per clock.
- R5: The gain code saturates at 7 and at 0. Requests beyond either limit have no effect.
- R6: The exponent output equals the gain code delayed by the settle-delay input, measured in clocks. A delay of 0 makes the exponent follow the gain code in the same cycle.
- R7: After a change, increase and decrease requests are ignored for settle-delay clocks, and the dwell count does not advance during that time.
- R8: On the first clock at which the enable is high after being low, the gain code and the exponent are both forced to 000.
- R9: While the enable is low, the gain code, the exponent, the dwell count and the settle count all hold their values.
- R10: During reset the gain code and the exponent both read 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Loop enable; a rising edge restarts the loop at gain 000 |
| sample_in | input | 14 | Signed two's-complement converter sample |
| thr_upper | input | 10 | Upper magnitude limit |
| thr_lower | input | 10 | Lower magnitude limit |
| dwell_cycles | input | 20 | Dwell time in clocks before the gain may rise |
| settle_delay | input | 6 | Exponent delay, and the window in which requests are ignored |
| gain_code | output | 3 | Code to the external gain-ranging amplifier |
| exp_out | output | 3 | Delayed code for digital relinearization |

## Verification
The bench applies exactly D and then D+1 low samples. A dwell counter that is off by one either steps too early on the shorter run or never steps on the longer one. It also applies magnitudes equal to each limit and one code past each limit, which exposes a non-strict comparison or a truncation of the magnitude on the wrong bits. Inside the busy window it holds an over-range signal and times the second step down to the exact clock, and it times the lag of the exponent at two delays including zero. It also checks that enable-low freezes everything, that re-enabling clears to 000, that the code saturates at both ends and that the most negative sample maps correctly. A design that mishandled any of these would show the wrong gain code or exponent at a known clock.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int GAIN_W = 3;
  typedef logic [GAIN_W-1:0] gain_t;
  localparam gain_t GAIN_MAX = '1;
  localparam gain_t GAIN_MIN = '0;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/agc_reset_sync.sv
module agc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/agc_magnitude.sv
module agc_magnitude #(
  parameter int SAMPLE_W = 14,
  parameter int THR_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [THR_W-1:0]    mag_o
);
  localparam int MAG_W = SAMPLE_W - 1;
  localparam int SHIFT = MAG_W - THR_W;

  logic [SAMPLE_W-1:0] abs_full;
  logic [MAG_W-1:0]    abs_sat;
  logic [THR_W-1:0]    mag_d;
  logic [THR_W-1:0]    mag_q;

  // Two's-complement absolute value; the most negative code overflows into the top bit.
  always_comb begin
    if (sample_i[SAMPLE_W-1]) begin
      abs_full = ~sample_i + {{(SAMPLE_W-1){1'b0}}, 1'b1};
    end else begin
      abs_full = sample_i;
    end
  end

  // Limit to the largest positive magnitude, then keep the upper THR_W bits.
  always_comb begin
    if (abs_full[MAG_W]) begin
      abs_sat = '1;
    end else begin
      abs_sat = abs_full[MAG_W-1:0];
    end
  end

  generate
    if (SHIFT > 0) begin : g_shift
      assign mag_d = THR_W'(abs_sat >> SHIFT);
    end else begin : g_direct
      assign mag_d = THR_W'(abs_sat);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
    end else begin
      mag_q <= mag_d;
    end
  end

  assign mag_o = mag_q;

  // R1: a zero sample always yields a zero magnitude one clock later
  p_zero_mag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i == '0) |=> (mag_q == '0));
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int THR_W   = 10,
  parameter int DWELL_W = 20,
  parameter int DELAY_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic [THR_W-1:0]   mag_i,
  input  logic [THR_W-1:0]   thr_upper_i,
  input  logic [THR_W-1:0]   thr_lower_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic [DELAY_W-1:0] delay_i,
  output gain_t              gain_o,
  output logic               restart_o
);
  localparam logic [DWELL_W-1:0] DWELL_ONE = DWELL_W'(1);

  logic               en_q;
  logic               en_rise;
  logic               upd_en;
  logic               above;
  logic               below;
  step_e              step;
  gain_t              gain_q, gain_d;
  logic [DWELL_W-1:0] dwell_q, dwell_d;
  logic [DELAY_W-1:0] settle_q, settle_d;
  logic               busy;

  assign en_rise = enable_i & ~en_q;
  assign upd_en  = enable_i;
  assign above   = mag_i > thr_upper_i;
  assign below   = mag_i < thr_lower_i;
  assign busy    = settle_q != '0;

  // Decide which step the current magnitude asks for, and advance the dwell timer.
  always_comb begin
    step    = STEP_HOLD;
    dwell_d = dwell_q;
    if (busy) begin
      dwell_d = '0;
    end else if (above) begin
      dwell_d = '0;
      if (gain_q != GAIN_MIN) step = STEP_DOWN;
    end else if (below) begin
      if (dwell_q == '0) begin
        dwell_d = (dwell_i == '0) ? DWELL_ONE : dwell_i;
      end else if (dwell_q == DWELL_ONE) begin
        dwell_d = '0;
        if (gain_q != GAIN_MAX) step = STEP_UP;
      end else begin
        dwell_d = dwell_q - DWELL_ONE;
      end
    end else begin
      dwell_d = '0;
    end
  end

  // Next gain and settle window.
  always_comb begin
    gain_d   = gain_q;
    settle_d = busy ? settle_q - DELAY_W'(1) : settle_q;
    unique case (step)
      STEP_UP: begin
        gain_d   = gain_q + gain_t'(1);
        settle_d = delay_i;
      end
      STEP_DOWN: begin
        gain_d   = gain_q - gain_t'(1);
        settle_d = delay_i;
      end
      default: ;
    endcase
    if (en_rise) begin
      gain_d   = GAIN_MIN;
      settle_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= enable_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q   <= GAIN_MIN;
      dwell_q  <= '0;
      settle_q <= '0;
    end else if (upd_en) begin
      gain_q   <= gain_d;
      dwell_q  <= en_rise ? '0 : dwell_d;
      settle_q <= settle_d;
    end
  end

  assign gain_o    = gain_q;
  assign restart_o = en_rise;

  // R4: the code moves by at most one step per clock
  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> (({1'b0, gain_q} == {1'b0, $past(gain_q)}) ||
                  ({1'b0, gain_q} == {1'b0, $past(gain_q)} + 4'd1) ||
                  ({1'b0, gain_q} + 4'd1 == {1'b0, $past(gain_q)})));

  // R3: a rise is only granted on a below-limit magnitude
  p_rise_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!below && !en_rise) |=> ({1'b0, gain_q} != {1'b0, $past(gain_q)} + 4'd1));

  // R5: no wrap from top to bottom or from bottom to top
  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q == GAIN_MAX && !en_rise) |=> (gain_q != GAIN_MIN));
  p_sat_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q == GAIN_MIN) |=> (gain_q != GAIN_MAX));

  // R7: the code is frozen while a change is settling
  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en_rise) |=> $stable(gain_q));

  // R8: restart forces minimum gain
  p_restart_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (gain_q == GAIN_MIN));

  // R9: nothing moves while disabled
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> ($stable(gain_q) && $stable(dwell_q) && $stable(settle_q)));
endmodule

// File: rtl/agc_exp_delay.sv
module agc_exp_delay
  import agc_pkg::*;
#(
  parameter int DELAY_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en_i,
  input  logic               clear_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  gain_t              din_i,
  output gain_t              dout_o
);
  localparam int DEPTH = (1 << DELAY_W) - 1;

  gain_t stage_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      gain_t stage_in;
      if (i == 0) begin : g_head
        assign stage_in = din_i;
      end else begin : g_body
        assign stage_in = stage_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[i] <= GAIN_MIN;
        end else if (clear_i) begin
          stage_q[i] <= GAIN_MIN;
        end else if (shift_en_i) begin
          stage_q[i] <= stage_in;
        end
      end
    end
  endgenerate

  assign dout_o = (delay_i == '0) ? din_i : stage_q[delay_i - DELAY_W'(1)];

  // R8: a restart flushes the whole line, so the exponent reads zero
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (dout_o == GAIN_MIN));

  // R9: the line is frozen while disabled
  p_line_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en_i && !clear_i) |=> $stable(stage_q[0]));
endmodule

// File: rtl/agc_gain_ranger.sv
module agc_gain_ranger #(
  parameter int SAMPLE_W = 14,
  parameter int THR_W    = 10,
  parameter int DWELL_W  = 20,
  parameter int DELAY_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [THR_W-1:0]    thr_upper,
  input  logic [THR_W-1:0]    thr_lower,
  input  logic [DWELL_W-1:0]  dwell_cycles,
  input  logic [DELAY_W-1:0]  settle_delay,
  output logic [2:0]          gain_code,
  output logic [2:0]          exp_out
);
  import agc_pkg::*;

  logic             rst_core_n;
  logic [THR_W-1:0] mag;
  gain_t            gain;
  gain_t            exp_dly;
  logic             restart;

  agc_reset_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_core_n)
  );

  agc_magnitude #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_mag (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sample_i (sample_in),
    .mag_o    (mag)
  );

  agc_gain_ctrl #(.THR_W(THR_W), .DWELL_W(DWELL_W), .DELAY_W(DELAY_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .enable_i    (enable),
    .mag_i       (mag),
    .thr_upper_i (thr_upper),
    .thr_lower_i (thr_lower),
    .dwell_i     (dwell_cycles),
    .delay_i     (settle_delay),
    .gain_o      (gain),
    .restart_o   (restart)
  );

  agc_exp_delay #(.DELAY_W(DELAY_W)) u_dly (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .shift_en_i (enable),
    .clear_i    (restart),
    .delay_i    (settle_delay),
    .din_i      (gain),
    .dout_o     (exp_dly)
  );

  assign gain_code = gain;
  assign exp_out   = exp_dly;

  // R10: both outputs read zero while the core is in reset
  p_reset_zero_r10: assert property (@(posedge clk)
    !rst_core_n |-> (gain_code == 3'd0 && exp_out == 3'd0));
endmodule

// File: tb/agc_gain_ranger_test.sv
module agc_gain_ranger_test;
  logic        clk;
  logic        rst_n;
  logic        enable;
  logic [13:0] sample_in;
  logic [9:0]  thr_upper;
  logic [9:0]  thr_lower;
  logic [19:0] dwell_cycles;
  logic [5:0]  settle_delay;
  logic [2:0]  gain_code;
  logic [2:0]  exp_out;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // Magnitudes against limits 100 / 800 (sample >> 3)
  localparam int LOW_S  = 400;   // mag 50, below
  localparam int MID_S  = 3200;  // mag 400, in band
  localparam int HIGH_S = 7200;  // mag 900, above

  agc_gain_ranger uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sample_in    (sample_in),
    .thr_upper    (thr_upper),
    .thr_lower    (thr_lower),
    .dwell_cycles (dwell_cycles),
    .settle_delay (settle_delay),
    .gain_code    (gain_code),
    .exp_out      (exp_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic feed(input int v, input int n);
    sample_in = 14'(v);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gain_change(input string req, output bit seen);
    logic [2:0] prev;
    prev = gain_code;
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (gain_code != prev) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) check(req, "gain change never seen", 0, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R10", "gain in reset", gain_code, 0);
    check("R10", "exp in reset", exp_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "gain after reset", gain_code, 0);
  endtask

  task automatic t_disabled;
    feed(LOW_S, 40);
    check("R9", "gain while disabled", gain_code, 0);
  endtask

  task automatic t_enable;
    enable = 1'b1;
    feed(MID_S, 10);
    check("R8", "gain after enable", gain_code, 0);
    check("R8", "exp after enable", exp_out, 0);
  endtask

  task automatic t_dwell;
    feed(LOW_S, 5); feed(MID_S, 10);
    check("R3", "D low samples give no rise", gain_code, 0);
    feed(LOW_S, 6); feed(MID_S, 10);
    check("R3", "D+1 low samples give one rise", gain_code, 1);
    feed(LOW_S, 4); feed(MID_S, 1); feed(LOW_S, 4); feed(MID_S, 10);
    check("R3", "interrupted dwell restarts", gain_code, 1);
  endtask

  task automatic t_delay4;
    bit seen;
    int k;
    sample_in = 14'(LOW_S);
    wait_gain_change("R6", seen);
    sample_in = 14'(MID_S);
    k = 0;
    while (exp_out != gain_code && k < 100) begin
      @(negedge clk);
      k++;
    end
    check("R6", "exp lag at delay 4", k, 4);
    feed(MID_S, 10);
    check("R6", "gain after timed rise", gain_code, 2);
  endtask

  task automatic t_equal;
    feed(800, 20);  check("R2", "mag equal lower", gain_code, 2);
    feed(807, 20);  check("R2", "mag floor equal lower", gain_code, 2);
    feed(6400, 20); check("R2", "mag equal upper", gain_code, 2);
    feed(6407, 20); check("R2", "mag floor equal upper", gain_code, 2);
    feed(799, 6); feed(MID_S, 10);
    check("R2", "one code under lower rises", gain_code, 3);
    feed(6408, 1); feed(MID_S, 10);
    check("R4", "single sample over upper drops", gain_code, 2);
  endtask

  task automatic t_negative;
    feed(-HIGH_S, 1); feed(MID_S, 10);
    check("R1", "negative over-range drops", gain_code, 1);
    feed(-LOW_S, 6); feed(MID_S, 10);
    check("R1", "negative small rises", gain_code, 2);
    feed(-8192, 1); feed(MID_S, 10);
    check("R1", "most negative sample is over-range", gain_code, 1);
  endtask

  task automatic t_latency;
    feed(HIGH_S, 1);
    check("R4", "no change one edge after sample", gain_code, 2);
    feed(MID_S, 1);
    check("R4", "drop two edges after sample", gain_code, 1);
    feed(MID_S, 10);
  endtask

  task automatic t_busy;
    bit seen;
    feed(MID_S, 70);
    settle_delay = 6'd20;
    feed(MID_S, 70);
    feed(LOW_S, 6); feed(MID_S, 25);
    feed(LOW_S, 6); feed(MID_S, 25);
    check("R7", "setup gain for busy test", gain_code, 3);
    sample_in = 14'(HIGH_S);
    wait_gain_change("R7", seen);
    check("R7", "first drop", gain_code, 2);
    repeat (20) @(negedge clk);
    check("R7", "request ignored in window", gain_code, 2);
    @(negedge clk);
    check("R7", "request served after window", gain_code, 1);
    feed(MID_S, 30);
    check("R6", "exp follows at delay 20", exp_out, 1);
    settle_delay = 6'd4;
    feed(MID_S, 10);
  endtask

  task automatic t_saturate;
    dwell_cycles = 20'd2;
    feed(LOW_S, 150);
    check("R5", "gain saturates high", gain_code, 7);
    check("R5", "exp saturates high", exp_out, 7);
    feed(LOW_S, 50);
    check("R5", "gain stays at 7", gain_code, 7);
    feed(HIGH_S, 150);
    check("R5", "gain saturates low", gain_code, 0);
    check("R5", "exp saturates low", exp_out, 0);
  endtask

  task automatic t_delay0;
    bit seen;
    feed(MID_S, 10);
    settle_delay = 6'd0;
    feed(MID_S, 10);
    sample_in = 14'(LOW_S);
    wait_gain_change("R6", seen);
    sample_in = 14'(MID_S);
    check("R6", "exp same cycle at delay 0", exp_out, gain_code);
    check("R6", "gain at delay 0", gain_code, 1);
    feed(MID_S, 10);
  endtask

  task automatic t_rehold;
    enable = 1'b0;
    feed(HIGH_S, 40);
    check("R9", "gain held when disabled", gain_code, 1);
    check("R9", "exp held when disabled", exp_out, 1);
    feed(LOW_S, 40);
    check("R9", "gain held on low input", gain_code, 1);
    enable = 1'b1;
    @(negedge clk);
    check("R8", "gain cleared on re-enable", gain_code, 0);
    check("R8", "exp cleared on re-enable", exp_out, 0);
  endtask

  initial begin
    rst_n        = 1'b0;
    enable       = 1'b0;
    sample_in    = '0;
    thr_upper    = 10'd800;
    thr_lower    = 10'd100;
    dwell_cycles = 20'd5;
    settle_delay = 6'd4;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_enable;
    t_dwell;
    t_delay4;
    t_equal;
    t_negative;
    feed(LOW_S, 6); feed(MID_S, 10);
    t_latency;
    t_busy;
    t_saturate;
    t_delay0;
    t_rehold;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule